// File: doc/BRIEF.md
# Display Controller Power-Up Sequencer

This block brings an SPI-attached TFT display controller out of reset and plays a fixed start-up program into it. It first holds the controller's active-low reset line low for a set number of milliseconds, releases it, waits a further settling time, and then walks an internal program of 32-bit entries. Each entry carries a tag in bits [31:8]. One tag marks a command byte and another marks a millisecond wait. Every other entry is a data byte for the command before it.

Command and data bytes go to an external byte-wide SPI transmitter over a valid/ready handshake. A data/command select bit travels with each byte: low for commands and high for data. After the transmitter accepts a byte, the sequencer waits for the transmitter to report that it is idle before it reads the next entry. Waits are counted in milliseconds, and a parameter gives the number of clock cycles in one millisecond. When the last entry has finished, the block raises a done flag and holds it. A synchronous restart input runs the whole reset pulse and program again from entry 0.

Top module: `lcd_init_seq`

## Requirements
- R1: While `rst_ni` is low and after any restart, `panel_rst_no` is driven low with `tx_valid_o` and `done_o` low. The reset stays low for PANEL_RST_MS*CYC_PER_MS cycles, within two cycles. After `panel_rst_no` rises, no byte is accepted for at least POST_RST_MS*CYC_PER_MS cycles.
- R2: An entry whose bits [31:8] equal 24'h010000 sends its bits [7:0] as one byte with `tx_dc_o` = 0.
- R3: An entry whose bits [31:8] match neither tag sends its bits [7:0] as one byte with `tx_dc_o` = 1, whatever those upper bits hold.
- R4: An entry whose bits [31:8] equal 24'h020000 sends no byte. It stalls the program for its bits [7:0] times CYC_PER_MS cycles.
- R5: A wait entry whose bits [7:0] are 0 adds no millisecond wait. The next byte follows within the normal handshake latency.
- R6: Once `tx_valid_o` is raised, it stays high with `tx_byte_o` and `tx_dc_o` stable until `tx_ready_i` is seen. No new byte is offered while `tx_idle_i` is low after an acceptance.
- R7: With the default program, the bytes go out as {dc,byte}, in this order: 0B0, 100, 03A, 1pp, 0C5, 100, 191, 180, 100, 011, 036, 128, then a 255 ms wait, then 029. Here pp is 55 when PIX16 = 1 and 66 when PIX16 = 0.
- R8: After the last entry completes, `done_o` goes high and stays high, and no further byte is offered until a reset or a restart.
- R9: `restart_i`, sampled on a clock edge, takes the block back to the R1 state on that edge and replays the program from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Synchronous restart of the reset pulse and the program |
| tx_valid_o | output | 1 | Byte offered to the SPI transmitter |
| tx_byte_o | output | 8 | Byte value |
| tx_dc_o | output | 1 | Data/command select: 0 command, 1 data |
| tx_ready_i | input | 1 | Transmitter accepts the offered byte |
| tx_idle_i | input | 1 | Transmitter has finished shifting |
| panel_rst_no | output | 1 | Active-low reset to the display controller |
| done_o | output | 1 | Program complete |

## Verification
The hardest case to reach is the gap between acceptance and idle. The sequencer has to sit in the drain state while the transmitter is busy, and it must not be allowed to offer the next byte early. The bench models a transmitter whose ready line is low two cycles out of three and whose idle line drops for several cycles after each acceptance. Any byte offered during that busy window counts as a failure. Wait lengths are measured as cycle gaps between acceptances: a 255 ms wait on one side, and a zero-length wait that must stay below one millisecond on the other. A second instance, with the 18-bit pixel variant and an always-ready transmitter, confirms the parameter-selected data byte.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  localparam logic [23:0] TAG_CMD = 24'h010000;
  localparam logic [23:0] TAG_DLY = 24'h020000;

  localparam int PROG_LEN = 15;
  localparam int IDX_W    = $clog2(PROG_LEN);

  typedef enum logic [1:0] {ENT_CMD, ENT_DATA, ENT_DLY} ent_kind_e;

  typedef enum logic [2:0] {
    S_RST_LOW, S_RST_WAIT, S_FETCH, S_SEND, S_DRAIN, S_DELAY, S_DONE
  } seq_state_e;

  function automatic ent_kind_e ent_kind(input logic [31:0] w);
    if (w[31:8] == TAG_CMD)      return ENT_CMD;
    else if (w[31:8] == TAG_DLY) return ENT_DLY;
    else                         return ENT_DATA;
  endfunction

  // default start-up program; entry 8 carries junk upper bits on purpose
  function automatic logic [31:0] prog_entry(input int idx, input bit pix16);
    case (idx)
      0:  return 32'h0100_00B0;
      1:  return 32'h0000_0000;
      2:  return 32'h0100_003A;
      3:  return pix16 ? 32'h0000_0055 : 32'h0000_0066;
      4:  return 32'h0200_0000;
      5:  return 32'h0100_00C5;
      6:  return 32'h0000_0000;
      7:  return 32'h0000_0091;
      8:  return 32'h0300_0080;
      9:  return 32'h0000_0000;
      10: return 32'h0100_0011;
      11: return 32'h0100_0036;
      12: return 32'h0000_0028;
      13: return 32'h0200_00FF;
      14: return 32'h0100_0029;
      default: return 32'h0200_0000;
    endcase
  endfunction

endpackage

// File: rtl/lcd_init_rom.sv
module lcd_init_rom
  import lcd_init_pkg::*;
#(
  parameter bit PIX16 = 1'b1
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [31:0]      word_o
);

  logic [31:0] prog [PROG_LEN];

  for (genvar g = 0; g < PROG_LEN; g++) begin : g_ent
    assign prog[g] = prog_entry(g, PIX16);
  end

  always_comb begin
    word_o = {TAG_DLY, 8'h00};
    for (int i = 0; i < PROG_LEN; i++)
      if (idx_i == IDX_W'(i)) word_o = prog[i];
  end

endmodule

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
  parameter int CYC_PER_MS = 50000,
  parameter int MS_W       = 8,
  parameter int INIT_MS    = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            expired_o
);

  localparam int CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(CYC_PER_MS - 1);

  logic [CW-1:0]   cyc_q;
  logic [MS_W-1:0] ms_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      ms_q  <= MS_W'(INIT_MS);
    end else if (load_i) begin
      cyc_q <= '0;
      ms_q  <= ms_i;
    end else if (ms_q != '0) begin
      if (cyc_q == CYC_LAST) begin
        cyc_q <= '0;
        ms_q  <= ms_q - 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  assign expired_o = (ms_q == '0);

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int CYC_PER_MS   = 50000,
  parameter int PANEL_RST_MS = 10,
  parameter int POST_RST_MS  = 120,
  parameter bit PIX16        = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_byte_o,
  output logic       tx_dc_o,
  input  logic       tx_ready_i,
  input  logic       tx_idle_i,
  output logic       panel_rst_no,
  output logic       done_o
);

  localparam int MS_W = 8;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PROG_LEN - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       byte_q, byte_d;
  logic             dc_q, dc_d;
  logic [31:0]      word;
  ent_kind_e        kind;
  logic             tmr_load, tmr_exp;
  logic [MS_W-1:0]  tmr_ms;

  lcd_init_rom #(.PIX16(PIX16)) u_rom (
    .idx_i  (idx_q),
    .word_o (word)
  );

  lcd_ms_timer #(
    .CYC_PER_MS (CYC_PER_MS),
    .MS_W       (MS_W),
    .INIT_MS    (PANEL_RST_MS)
  ) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .ms_i      (tmr_ms),
    .expired_o (tmr_exp)
  );

  assign kind = ent_kind(word);

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    byte_d   = byte_q;
    dc_d     = dc_q;
    tmr_load = 1'b0;
    tmr_ms   = '0;
    if (restart_i) begin
      state_d  = S_RST_LOW;
      idx_d    = '0;
      tmr_load = 1'b1;
      tmr_ms   = MS_W'(PANEL_RST_MS);
    end else begin
      unique case (state_q)
        S_RST_LOW: if (tmr_exp) begin
          state_d  = S_RST_WAIT;
          tmr_load = 1'b1;
          tmr_ms   = MS_W'(POST_RST_MS);
        end
        S_RST_WAIT: if (tmr_exp) begin
          state_d = S_FETCH;
          idx_d   = '0;
        end
        S_FETCH: begin
          if (kind == ENT_DLY) begin
            if (word[7:0] == 8'd0) begin
              // zero wait: skip straight on
              if (idx_q == IDX_LAST) state_d = S_DONE;
              else idx_d = idx_q + 1'b1;
            end else begin
              state_d  = S_DELAY;
              tmr_load = 1'b1;
              tmr_ms   = word[7:0];
            end
          end else begin
            state_d = S_SEND;
            byte_d  = word[7:0];
            dc_d    = (kind == ENT_DATA);
          end
        end
        S_SEND:  if (tx_ready_i) state_d = S_DRAIN;
        S_DRAIN, S_DELAY: begin
          if ((state_q == S_DRAIN) ? tx_idle_i : tmr_exp) begin
            if (idx_q == IDX_LAST) state_d = S_DONE;
            else begin
              state_d = S_FETCH;
              idx_d   = idx_q + 1'b1;
            end
          end
        end
        S_DONE: ;
        default: state_d = S_DONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_RST_LOW;
      idx_q   <= '0;
      byte_q  <= '0;
      dc_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      byte_q  <= byte_d;
      dc_q    <= dc_d;
    end
  end

  assign tx_valid_o   = (state_q == S_SEND);
  assign tx_byte_o    = byte_q;
  assign tx_dc_o      = dc_q;
  assign panel_rst_no = (state_q != S_RST_LOW);
  assign done_o       = (state_q == S_DONE);

endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       restart_i,
  input logic       tx_valid_o,
  input logic [7:0] tx_byte_o,
  input logic       tx_dc_o,
  input logic       tx_ready_i,
  input logic       panel_rst_no,
  input logic       done_o
);

  p_quiet_in_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !panel_rst_no |-> (!tx_valid_o && !done_o));

  p_hold_until_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !restart_i) |=>
      (tx_valid_o && $stable(tx_byte_o) && $stable(tx_dc_o)));

  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !restart_i) |=> done_o);

  p_done_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !tx_valid_o);

  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!panel_rst_no && !done_o && !tx_valid_o));

endmodule

bind lcd_init_seq lcd_init_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .restart_i    (restart_i),
  .tx_valid_o   (tx_valid_o),
  .tx_byte_o    (tx_byte_o),
  .tx_dc_o      (tx_dc_o),
  .tx_ready_i   (tx_ready_i),
  .panel_rst_no (panel_rst_no),
  .done_o       (done_o)
);

// File: tb/lcd_init_seq_tb.sv
module lcd_init_seq_tb;

  localparam int CYC  = 20;
  localparam int PRST = 2;
  localparam int POST = 3;
  localparam int BUSY = 4;
  localparam int NB   = 13;

  // expected {dc, byte} stream (R7)
  localparam logic [8:0] EXP [NB] = '{
    9'h0B0, 9'h100, 9'h03A, 9'h155, 9'h0C5, 9'h100, 9'h191,
    9'h180, 9'h100, 9'h011, 9'h036, 9'h128, 9'h029};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic ready = 1'b0;
  logic idle = 1'b1;
  logic valid, dc, prst_n, done;
  logic [7:0] tbyte;
  logic valid_b, dc_b, prst_nb, done_b;
  logic [7:0] tbyte_b;

  always #5 clk = ~clk;

  lcd_init_seq #(.CYC_PER_MS(CYC), .PANEL_RST_MS(PRST), .POST_RST_MS(POST),
                 .PIX16(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart),
    .tx_valid_o(valid), .tx_byte_o(tbyte), .tx_dc_o(dc),
    .tx_ready_i(ready), .tx_idle_i(idle),
    .panel_rst_no(prst_n), .done_o(done));

  lcd_init_seq #(.CYC_PER_MS(CYC), .PANEL_RST_MS(PRST), .POST_RST_MS(POST),
                 .PIX16(1'b0)) u_dut_b (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(1'b0),
    .tx_valid_o(valid_b), .tx_byte_o(tbyte_b), .tx_dc_o(dc_b),
    .tx_ready_i(1'b1), .tx_idle_i(1'b1),
    .panel_rst_no(prst_nb), .done_o(done_b));

  int n_chk = 0, n_fail = 0;
  int cyc = 0, busy = 0, nacc = 0, nacc_b = 0, viol = 0;
  int low_cnt = 0, rise_cyc = 0;
  bit pend = 0, rise_seen = 0;
  logic [8:0] log_v [32];
  int acc_cyc [32];
  logic [8:0] log_b [32];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // transmitter model and monitor, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (pend) begin busy = BUSY; pend = 0; end
      else if (busy > 0) busy--;
      idle  = (busy == 0);
      ready = (cyc % 3 == 0);
      if (rst_n && valid && !idle) viol++;
      if (rst_n && valid && ready) begin
        if (nacc < 32) begin log_v[nacc] = {dc, tbyte}; acc_cyc[nacc] = cyc; end
        nacc++;
        pend = 1;
      end
      if (rst_n && valid_b) begin
        if (nacc_b < 32) log_b[nacc_b] = {dc_b, tbyte_b};
        nacc_b++;
      end
      if (rst_n && !prst_n) low_cnt++;
      if (rst_n && prst_n && !rise_seen) begin rise_seen = 1; rise_cyc = cyc; end
    end
  end

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done == 1'b1, req, done, 1);
  endtask

  task automatic check_run(input string tag);
    for (int k = 0; k < NB; k++)
      chk(log_v[k] == EXP[k], "R7 byte stream", log_v[k], EXP[k]);
    chk(nacc == NB, "R8 byte count", nacc, NB);
    chk(low_cnt >= PRST*CYC && low_cnt <= PRST*CYC + 2, "R1 reset width", low_cnt, PRST*CYC);
    chk(acc_cyc[0] - rise_cyc >= POST*CYC && acc_cyc[0] - rise_cyc <= POST*CYC + 10,
        "R1 settle time", acc_cyc[0] - rise_cyc, POST*CYC);
    chk(viol == 0, "R6 offer while busy", viol, 0);
    $display("run %s: %0d bytes", tag, nacc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(prst_n == 1'b0, "R1 panel reset low", prst_n, 0);
    chk(valid == 1'b0 && done == 1'b0, "R1 idle in reset", {valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(prst_n == 1'b0, "R1 panel reset held", prst_n, 0);

    wait_done("R8 done raised");
    check_run("first");
    // R2/R3: command and tagged-junk data lane
    chk(log_v[0][8] == 1'b0 && log_v[0][7:0] == 8'hB0, "R2 command dc low", log_v[0], 9'h0B0);
    chk(log_v[7] == 9'h180, "R3 junk upper bits still data", log_v[7], 9'h180);
    // R4: 255 ms wait between 0x28 and 0x29
    chk(acc_cyc[12] - acc_cyc[11] >= 255*CYC && acc_cyc[12] - acc_cyc[11] <= 255*CYC + 20,
        "R4 delay length", acc_cyc[12] - acc_cyc[11], 255*CYC);
    // R5: zero wait between 0x55 and 0xC5
    chk(acc_cyc[4] - acc_cyc[3] <= 15, "R5 zero delay", acc_cyc[4] - acc_cyc[3], 15);
    // R7: 18-bit variant
    chk(nacc_b == NB && log_b[3] == 9'h166, "R7 pixel format 0x66", log_b[3], 9'h166);

    // R8: stays done and silent
    repeat (50) @(negedge clk);
    chk(done == 1'b1, "R8 done sticky", done, 1);
    chk(nacc == NB, "R8 no bytes after done", nacc, NB);

    // R9: restart
    restart = 1'b1;
    nacc = 0; low_cnt = 0; rise_seen = 0;
    @(negedge clk);
    restart = 1'b0;
    chk(prst_n == 1'b0 && done == 1'b0, "R9 restart to reset", {prst_n, done}, 0);
    wait_done("R9 done after restart");
    check_run("restart");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule